// File: doc/BRIEF.md
# Full-Scale DSD Automute and Zero-Data Monitor

This block watches the two channels of a one-bit DSD stream and the two channels of a PCM sample stream. On the DSD side, a channel is at full scale when it has carried a long run of identical bits. Either channel at full scale raises a mute request for the output path, provided automute is enabled. Two flags show which channel is at full scale.

Once the full-scale condition ends, the mute is released in one of two ways. In the automatic policy, the mute drops as soon as neither channel is at full scale. In the hold policy, the mute stays latched until software pulses a release input.

On the PCM side, a channel is silent when it has carried a long run of all-zero samples. The silence condition drives two indicator pins. In per-channel mode, each pin reflects its own channel. In combined mode, both pins show the AND of the two channels. An invert control flips the level of both pins, and when zero detection is disabled the pins rest at their inactive level.

Top module: `fullscale_mute_monitor`

## Requirements
- R1: On each `dsd_stb`, a channel's run counter increments when the new bit equals that channel's previous bit and restarts at 1 otherwise; the first bit after reset counts as 1. `full_left`/`full_right` is 1 while the count is at least `RUN_LEN`, which is 256 by default. The flag appears in the cycle after the strobe that completes the run.
- R2: With `cfg_mute_en`=1, `mute_req` is 1 in the cycle after either full-scale flag is 1.
- R3: In the automatic policy (`cfg_hold`=0), `mute_req` drops one cycle after both full-scale flags are 0.
- R4: In the hold policy (`cfg_hold`=1), `mute_req` stays at 1 after the full-scale condition ends, until a one-cycle `sw_release` pulse arrives while neither flag is set. It clears in the cycle after that pulse.
- R5: `sw_release` has no effect when no mute is held: it does not raise `mute_req`, and it does not clear `mute_req` while a full-scale flag is still set.
- R6: With `cfg_mute_en`=0, `mute_req` is 0 one cycle later and stays 0. The full-scale flags still report detection.
- R7: On each `pcm_stb`, a channel's zero counter increments (saturating) on an all-zero sample. The channel is silent once `ZERO_LEN` consecutive zero samples have arrived, which is 8192 by default.
- R8: A nonzero sample on a channel clears that channel's silence condition in the cycle after its strobe.
- R9: With `cfg_zero_en`=1 and `cfg_zero_and`=0, `zero_pin[0]` shows the left channel's silence and `zero_pin[1]` shows the right channel's. With `cfg_zero_and`=1, both pins show left AND right.
- R10: With `cfg_zero_inv`=1, both `zero_pin` bits are inverted, so 1 is the inactive level.
- R11: With `cfg_zero_en`=0, both `zero_pin` bits sit at the inactive level: 0, or 1 when `cfg_zero_inv`=1.
- R12: Each channel is detected independently: a run or silence on one channel never sets the other channel's flag or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsd_stb | input | 1 | A DSD bit pair is valid this cycle |
| dsd_left | input | 1 | Left DSD bit |
| dsd_right | input | 1 | Right DSD bit |
| pcm_stb | input | 1 | A PCM sample pair is valid this cycle |
| pcm_left | input | SAMPLE_W | Left PCM sample |
| pcm_right | input | SAMPLE_W | Right PCM sample |
| cfg_mute_en | input | 1 | Automute enable |
| cfg_hold | input | 1 | 1 = hold release policy, 0 = automatic |
| sw_release | input | 1 | One-cycle software release pulse |
| cfg_zero_en | input | 1 | Zero detection enable |
| cfg_zero_and | input | 1 | 1 = both pins show left AND right |
| cfg_zero_inv | input | 1 | Invert zero-detect pin levels |
| mute_req | output | 1 | Mute request to the output path |
| full_left | output | 1 | Left channel at full scale |
| full_right | output | 1 | Right channel at full scale |
| zero_pin | output | 2 | Zero-detect pins, bit 0 left, bit 1 right |

## Verification
The bench builds the block with `RUN_LEN`=8, `ZERO_LEN`=16 and `SAMPLE_W`=16. With these lengths, the exact boundary of each detector is reachable in a few dozen strobes: one short of the run and the completing strobe, as well as the saturated state. This lets every policy transition and every zero-pin combination be walked directly. The counter widths derive from the lengths, so the same logic covers the default values of 256 and 8192.

// File: rtl/fsm_mon_pkg.sv
package fsm_mon_pkg;

  typedef struct packed {
    logic en;
    logic both;
    logic inv;
  } zero_cfg_t;

  // Pin levels from the per-channel silence states; bit 0 left, bit 1 right.
  function automatic logic [1:0] zero_levels(zero_cfg_t cfg, logic sil_l, logic sil_r);
    logic [1:0] act;
    if (!cfg.en)       act = 2'b00;
    else if (cfg.both) act = {2{sil_l & sil_r}};
    else               act = {sil_r, sil_l};
    return act ^ {2{cfg.inv}};
  endfunction

endpackage

// File: rtl/run_detector.sv
module run_detector #(
  parameter int RUN_LEN = 256,
  localparam int CW = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic bit_in,
  output logic full
);
  logic [CW-1:0] cnt_q;
  logic          last_q;

  function automatic logic [CW-1:0] next_cnt(logic [CW-1:0] c, logic same);
    if (!same)                     return CW'(1);
    else if (c >= CW'(RUN_LEN))    return c;
    else                           return c + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (stb) begin
      cnt_q  <= next_cnt(cnt_q, (bit_in == last_q) && (cnt_q != '0));
      last_q <= bit_in;
    end
  end

  assign full = (cnt_q >= CW'(RUN_LEN));
endmodule

// File: rtl/zero_detector.sv
module zero_detector #(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_LEN = 8192,
  localparam int CW = $clog2(ZERO_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                silent
);
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] next_cnt(logic [CW-1:0] c, logic is_zero);
    if (!is_zero)                  return '0;
    else if (c >= CW'(ZERO_LEN))   return c;
    else                           return c + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (stb) cnt_q <= next_cnt(cnt_q, sample == '0);
  end

  assign silent = (cnt_q >= CW'(ZERO_LEN));
endmodule

// File: rtl/mute_policy.sv
module mute_policy (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hold,
  input  logic release_pulse,
  input  logic any_full,
  output logic mute
);
  logic mute_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                              mute_q <= 1'b0;
    else if (!enable)                        mute_q <= 1'b0;
    else if (any_full)                       mute_q <= 1'b1;
    else if (mute_q && (!hold || release_pulse)) mute_q <= 1'b0;
  end

  assign mute = mute_q;
endmodule

// File: rtl/fullscale_mute_monitor.sv
module fullscale_mute_monitor
  import fsm_mon_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 256,
  parameter int ZERO_LEN = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dsd_stb,
  input  logic                dsd_left,
  input  logic                dsd_right,
  input  logic                pcm_stb,
  input  logic [SAMPLE_W-1:0] pcm_left,
  input  logic [SAMPLE_W-1:0] pcm_right,
  input  logic                cfg_mute_en,
  input  logic                cfg_hold,
  input  logic                sw_release,
  input  logic                cfg_zero_en,
  input  logic                cfg_zero_and,
  input  logic                cfg_zero_inv,
  output logic                mute_req,
  output logic                full_left,
  output logic                full_right,
  output logic [1:0]          zero_pin
);
  localparam int NCH = 2;

  logic [NCH-1:0]          dsd_bits;
  logic [NCH-1:0]          full_vec;
  logic [NCH-1:0]          silent_vec;
  logic [SAMPLE_W-1:0]     pcm_arr [NCH];
  logic                    any_full;
  zero_cfg_t               zcfg;

  assign dsd_bits   = {dsd_right, dsd_left};
  assign pcm_arr[0] = pcm_left;
  assign pcm_arr[1] = pcm_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    run_detector #(.RUN_LEN(RUN_LEN)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (dsd_stb),
      .bit_in (dsd_bits[ch]),
      .full   (full_vec[ch])
    );
    zero_detector #(.SAMPLE_W(SAMPLE_W), .ZERO_LEN(ZERO_LEN)) u_zero (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (pcm_stb),
      .sample (pcm_arr[ch]),
      .silent (silent_vec[ch])
    );
  end

  assign any_full = |full_vec;

  mute_policy u_policy (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (cfg_mute_en),
    .hold          (cfg_hold),
    .release_pulse (sw_release),
    .any_full      (any_full),
    .mute          (mute_req)
  );

  assign zcfg       = '{en: cfg_zero_en, both: cfg_zero_and, inv: cfg_zero_inv};
  assign zero_pin   = zero_levels(zcfg, silent_vec[0], silent_vec[1]);
  assign full_left  = full_vec[0];
  assign full_right = full_vec[1];
endmodule

// File: rtl/fullscale_mute_monitor_chk.sv
module fullscale_mute_monitor_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dsd_stb,
  input logic                pcm_stb,
  input logic [SAMPLE_W-1:0] pcm_left,
  input logic                cfg_mute_en,
  input logic                cfg_hold,
  input logic                sw_release,
  input logic                cfg_zero_en,
  input logic                cfg_zero_and,
  input logic                mute_req,
  input logic                full_left,
  input logic                full_right,
  input logic                sil_left,
  input logic [1:0]          zero_pin
);
  AST_FLAG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(full_left) |-> $past(dsd_stb)); // R1
  AST_MUTE_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) (cfg_mute_en && (full_left || full_right)) |=> mute_req); // R2
  AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_mute_en && !cfg_hold && !full_left && !full_right) |=> !mute_req); // R3
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (mute_req && cfg_mute_en && cfg_hold && !sw_release) |=> mute_req); // R4
  AST_NO_SPURIOUS_MUTE: assert property (@(posedge clk) disable iff (!rst_n) (!mute_req && !full_left && !full_right) |=> !mute_req); // R5
  AST_DISABLED_NO_MUTE: assert property (@(posedge clk) disable iff (!rst_n) !cfg_mute_en |=> !mute_req); // R6
  AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (pcm_stb && pcm_left != '0) |=> !sil_left); // R8
  AST_AND_MODE_EQUAL: assert property (@(posedge clk) disable iff (!rst_n) (cfg_zero_en && cfg_zero_and) |-> (zero_pin[0] == zero_pin[1])); // R9
endmodule

bind fullscale_mute_monitor fullscale_mute_monitor_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dsd_stb      (dsd_stb),
  .pcm_stb      (pcm_stb),
  .pcm_left     (pcm_left),
  .cfg_mute_en  (cfg_mute_en),
  .cfg_hold     (cfg_hold),
  .sw_release   (sw_release),
  .cfg_zero_en  (cfg_zero_en),
  .cfg_zero_and (cfg_zero_and),
  .mute_req     (mute_req),
  .full_left    (full_left),
  .full_right   (full_right),
  .sil_left     (silent_vec[0]),
  .zero_pin     (zero_pin)
);

// File: tb/fullscale_mute_monitor_bench.sv
module fullscale_mute_monitor_bench;
  localparam int SW = 16;
  localparam int RL = 8;
  localparam int ZL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dsd_stb = 0, dsd_left = 0, dsd_right = 0;
  logic pcm_stb = 0;
  logic [SW-1:0] pcm_left = '0, pcm_right = '0;
  logic cfg_mute_en = 0, cfg_hold = 0, sw_release = 0;
  logic cfg_zero_en = 0, cfg_zero_and = 0, cfg_zero_inv = 0;
  logic mute_req, full_left, full_right;
  logic [1:0] zero_pin;
  logic rtoggle = 0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fullscale_mute_monitor #(.SAMPLE_W(SW), .RUN_LEN(RL), .ZERO_LEN(ZL)) u_fullscale_mute_monitor (
    .clk(clk), .rst_n(rst_n), .dsd_stb(dsd_stb), .dsd_left(dsd_left), .dsd_right(dsd_right),
    .pcm_stb(pcm_stb), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .cfg_mute_en(cfg_mute_en), .cfg_hold(cfg_hold), .sw_release(sw_release),
    .cfg_zero_en(cfg_zero_en), .cfg_zero_and(cfg_zero_and), .cfg_zero_inv(cfg_zero_inv),
    .mute_req(mute_req), .full_left(full_left), .full_right(full_right), .zero_pin(zero_pin)
  );

  // {en, and, inv, left silent, right silent, expected pins[1:0]}
  localparam logic [6:0] ZTAB [8] = '{
    7'b000_11_00, 7'b001_11_11, 7'b100_10_01, 7'b100_01_10,
    7'b110_10_00, 7'b110_11_11, 7'b101_10_10, 7'b111_11_00
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Left bit as given; right alternates so it never runs.
  task automatic dsd_send(input logic l);
    dsd_stb = 1; dsd_left = l; rtoggle = ~rtoggle; dsd_right = rtoggle;
    @(negedge clk);
    dsd_stb = 0;
  endtask

  task automatic pcm_send(input logic [SW-1:0] l, input logic [SW-1:0] r);
    pcm_stb = 1; pcm_left = l; pcm_right = r;
    @(negedge clk);
    pcm_stb = 0;
  endtask

  task automatic pulse_release();
    sw_release = 1;
    @(negedge clk);
    sw_release = 0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset flags", {6'd0, full_right, full_left}, 8'd0);
    check("R6 reset mute", {7'd0, mute_req}, 8'd0);
    check("R11 reset pins", {6'd0, zero_pin}, 8'd0);

    // R1 boundary and R2 mute, automatic policy
    cfg_mute_en = 1;
    dsd_send(0);
    for (int i = 0; i < RL - 1; i++) dsd_send(1);
    check("R1 one short", {7'd0, full_left}, 8'd0);
    dsd_send(1);
    check("R1 run complete", {7'd0, full_left}, 8'd1);
    check("R12 right not full", {7'd0, full_right}, 8'd0);
    @(negedge clk);
    check("R2 mute raised", {7'd0, mute_req}, 8'd1);
    dsd_send(0);
    check("R1 bit change clears", {7'd0, full_left}, 8'd0);
    @(negedge clk);
    check("R3 auto release", {7'd0, mute_req}, 8'd0);

    // R4/R5 hold policy
    cfg_hold = 1;
    for (int i = 0; i < RL; i++) dsd_send(0);
    @(negedge clk);
    check("R4 held mute set", {7'd0, mute_req}, 8'd1);
    pulse_release();
    check("R5 release while full", {7'd0, mute_req}, 8'd1);
    dsd_send(1);
    idle(4);
    check("R4 mute stays held", {7'd0, mute_req}, 8'd1);
    pulse_release();
    check("R4 release clears", {7'd0, mute_req}, 8'd0);
    pulse_release();
    idle(1);
    check("R5 release no effect", {7'd0, mute_req}, 8'd0);

    // R6 disable
    cfg_hold = 0;
    cfg_mute_en = 0;
    for (int i = 0; i < RL; i++) dsd_send(1);
    idle(2);
    check("R6 disabled mute", {7'd0, mute_req}, 8'd0);
    check("R6 flag still set", {7'd0, full_left}, 8'd1);

    // R7/R8 zero boundary
    cfg_zero_en = 1;
    pcm_send(16'h0001, 16'h0001);
    for (int i = 0; i < ZL - 1; i++) pcm_send('0, 16'h0003);
    check("R7 one short", {6'd0, zero_pin}, 8'd0);
    pcm_send('0, 16'h0003);
    check("R7 silent left", {6'd0, zero_pin}, 8'd1);
    pcm_send(16'h8000, 16'h0003);
    check("R8 nonzero clears", {6'd0, zero_pin}, 8'd0);

    // R9/R10/R11/R12 table
    for (int row = 0; row < 8; row++) begin
      cfg_zero_en  = ZTAB[row][6];
      cfg_zero_and = ZTAB[row][5];
      cfg_zero_inv = ZTAB[row][4];
      for (int i = 0; i < ZL; i++)
        pcm_send(ZTAB[row][3] ? '0 : 16'h0010, ZTAB[row][2] ? '0 : 16'h0200);
      check($sformatf("R9 R10 R11 R12 row %0d", row), {6'd0, zero_pin}, {6'd0, ZTAB[row][1:0]});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule